// File: doc/BRIEF.md
# Zero-Suppressed Pixel Matrix Readout

This block drains a 64 by 64 pixel matrix and sends out only the pixels that have a stored hit. For each pixel the block keeps a hit flag, a time stamp and a digitised amplitude, all captured through a write port from the front end. A readout token travels through the pixels in chain order, which is row 0 first and then increasing row, and within a row by increasing column. A pixel with no hit passes the token on at once, so empty pixels cost no clock cycles. A pixel with a hit holds the token until its record has been shifted out. Its flag then clears and the token moves on.

Software or a sequencer pulses `start` to launch a frame. The row and column of the pixel holding the token come from two separate priority encoders. The stored time stamp and amplitude are fetched from a RAM that can be mapped to block RAM. The four fields are framed into one record and sent out bit-serially. When the token comes back from the end of the chain with no hit left, the block pulses `frame_done` and returns to idle.

Top module: `hitchain_readout`

## Requirements
- R1: While idle, a `hit_we` pulse stores a hit for pixel (`hit_row`, `hit_col`) together with `hit_ts` and `hit_amp`. A second write to the same pixel replaces its time stamp and amplitude.
- R2: A `hit_we` pulse while `busy` is high is ignored. It leaves no hit for the current frame or for any later frame.
- R3: Records leave in chain order: ascending row, and ascending column within a row.
- R4: Empty pixels cost no cycles. The first record starts on the third cycle after `start` is sampled, and consecutive records are separated by exactly 2 cycles with `ser_valid` low, whatever the distance between the hit pixels.
- R5: A record is 25 bits sent MSB first on `ser_data`, one bit per cycle with `ser_valid` high. The fields, first to last, are row[5:0], col[5:0], ts[4:0] and amp[7:0]. `rec_start` is high with the first bit only.
- R6: Each hit pixel is sent exactly once. Its flag is cleared after its record, so a following frame with no new writes is empty.
- R7: `frame_done` is a one-cycle pulse, with `busy` low, in the cycle after the last record's trailing scan cycle. With no hits stored, it comes on the second cycle after `start` is sampled.
- R8: A `start` pulse while `busy` is high is ignored and does not disturb the frame in progress.
- R9: After reset, `busy`, `ser_valid`, `rec_start` and `frame_done` are low and no pixel holds a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_we | input | 1 | Store a hit for the addressed pixel |
| hit_row | input | 6 | Row of the pixel being written |
| hit_col | input | 6 | Column of the pixel being written |
| hit_ts | input | 5 | Time stamp latched by the pixel |
| hit_amp | input | 8 | Digitised amplitude of the pixel |
| start | input | 1 | Launch a readout frame |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at end of frame |
| ser_data | output | 1 | Serial record bit, MSB first |
| ser_valid | output | 1 | High while record bits are on `ser_data` |
| rec_start | output | 1 | High with the first bit of each record |

## Verification
A flag that fails to clear makes the same pixel repeat, either in the same frame or in the next one. This shows on the port as an extra record within 27 cycles. A wrong row or column choice moves a record out of chain order or corrupts its leading 12 bits, and the bench catches this on the first bit that differs. A stall on an empty pixel, or a missing scan cycle, shifts `ser_valid` against the per-cycle reference model on the very next record. A lock that leaks during a frame shows as a stray record or a late `frame_done` in the following frame.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_FETCH = 2'd2,
    ST_SHIFT = 2'd3
  } hcr_state_t;
endpackage

// File: rtl/hcr_first_sel.sv
// Lowest-index set request wins: the address generator for one axis.
module hcr_first_sel #(
  parameter int N = 64,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         found
);
  always_comb begin
    idx   = '0;
    found = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/hcr_pixel_store.sv
// Per-pixel hit flags in flops, time stamp and amplitude in an inferable RAM.
module hcr_pixel_store #(
  parameter int NPIX  = 4096,
  parameter int DAT_W = 13,
  parameter int AW    = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             clr_en,
  input  logic [AW-1:0]    clr_addr,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DAT_W-1:0] rd_data,
  output logic [NPIX-1:0]  flags
);
  logic [DAT_W-1:0] mem [NPIX];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      if (wr_en)  flags[wr_addr]  <= 1'b1;
      if (clr_en) flags[clr_addr] <= 1'b0;
    end
  end

  // Writes are locked out during a frame, so they never meet a clear.
  assert_no_wr_clr_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && clr_en));
endmodule

// File: rtl/hcr_serializer.sv
// Loads one record and shifts it out MSB first, one bit per cycle.
module hcr_serializer #(
  parameter int REC_W = 25,
  parameter int CNT_W = $clog2(REC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REC_W-1:0] load_word,
  output logic             ser_data,
  output logic             ser_valid,
  output logic             rec_start,
  output logic             last_bit
);
  logic [REC_W-1:0] sreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg      <= '0;
      cnt       <= '0;
      ser_valid <= 1'b0;
      rec_start <= 1'b0;
    end else if (load) begin
      sreg      <= load_word;
      cnt       <= '0;
      ser_valid <= 1'b1;
      rec_start <= 1'b1;
    end else if (ser_valid) begin
      sreg      <= {sreg[REC_W-2:0], 1'b0};
      cnt       <= cnt + 1'b1;
      rec_start <= 1'b0;
      if (cnt == CNT_W'(REC_W - 1)) ser_valid <= 1'b0;
    end
  end

  assign ser_data = sreg[REC_W-1];
  assign last_bit = ser_valid && (cnt == CNT_W'(REC_W - 1));

  assert_start_in_valid_R5: assert property (@(posedge clk) disable iff (rst)
    rec_start |-> ser_valid);
  assert_bits_contiguous_R5: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && !rec_start) |-> $past(ser_valid));
  assert_load_marks_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> rec_start);
endmodule

// File: rtl/hitchain_readout.sv
module hitchain_readout #(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int TS_W  = 5,
  parameter int AMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hit_we,
  input  logic [$clog2(ROWS)-1:0] hit_row,
  input  logic [$clog2(COLS)-1:0] hit_col,
  input  logic [TS_W-1:0]         hit_ts,
  input  logic [AMP_W-1:0]        hit_amp,
  input  logic                    start,
  output logic                    busy,
  output logic                    frame_done,
  output logic                    ser_data,
  output logic                    ser_valid,
  output logic                    rec_start
);
  import hcr_pkg::*;

  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(COLS);
  localparam int NPIX  = ROWS * COLS;
  localparam int AW    = $clog2(NPIX);
  localparam int DAT_W = TS_W + AMP_W;
  localparam int REC_W = RW + CW + DAT_W;

  hcr_state_t state;
  logic [NPIX-1:0]  flags;
  logic [ROWS-1:0]  row_any;
  logic [COLS-1:0]  row_bits;
  logic [RW-1:0]    sel_row, cur_row;
  logic [CW-1:0]    sel_col, cur_col;
  logic             any_hit, col_found;
  logic [DAT_W-1:0] rd_data;
  logic             last_bit;
  logic             wr_ok, rd_go, clr_go, load_go;

  function automatic logic [AW-1:0] pix_addr(input logic [RW-1:0] r, input logic [CW-1:0] c);
    return AW'(int'(r) * COLS + int'(c));
  endfunction

  // Row address generator: one OR per row of the chain.
  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row_or
      assign row_any[r] = |flags[r*COLS +: COLS];
    end
  endgenerate

  hcr_first_sel #(.N(ROWS), .W(RW)) u_row_sel (
    .req(row_any), .idx(sel_row), .found(any_hit));

  // Column address generator works on the row that holds the token.
  assign row_bits = flags[int'(sel_row)*COLS +: COLS];

  hcr_first_sel #(.N(COLS), .W(CW)) u_col_sel (
    .req(row_bits), .idx(sel_col), .found(col_found));

  assign wr_ok   = hit_we && (state == ST_IDLE);
  assign rd_go   = (state == ST_SCAN) && any_hit;
  assign load_go = (state == ST_FETCH);
  assign clr_go  = (state == ST_SHIFT) && last_bit;

  hcr_pixel_store #(.NPIX(NPIX), .DAT_W(DAT_W), .AW(AW)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_ok), .wr_addr(pix_addr(hit_row, hit_col)), .wr_data({hit_ts, hit_amp}),
    .clr_en(clr_go), .clr_addr(pix_addr(cur_row, cur_col)),
    .rd_en(rd_go), .rd_addr(pix_addr(sel_row, sel_col)), .rd_data(rd_data),
    .flags(flags));

  hcr_serializer #(.REC_W(REC_W)) u_ser (
    .clk(clk), .rst(rst), .load(load_go),
    .load_word({cur_row, cur_col, rd_data}),
    .ser_data(ser_data), .ser_valid(ser_valid), .rec_start(rec_start),
    .last_bit(last_bit));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_row    <= '0;
      cur_col    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (state)
        ST_IDLE:  if (start) state <= ST_SCAN;
        ST_SCAN: begin
          if (any_hit) begin
            cur_row <= sel_row;
            cur_col <= sel_col;
            state   <= ST_FETCH;
          end else begin
            frame_done <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_FETCH: state <= ST_SHIFT;
        ST_SHIFT: if (last_bit) state <= ST_SCAN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  assert_done_empty_R7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!busy && !any_hit));
  assert_start_launch_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_locked_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !clr_go) |=> $stable(flags));
  assert_col_found_R3: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> col_found);
endmodule

// File: tb/hitchain_readout_tb_top.sv
module hitchain_readout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 64, COLS = 64, TS_W = 5, AMP_W = 8;
  localparam int NPIX = ROWS * COLS;
  localparam int REC_W = 6 + 6 + TS_W + AMP_W;

  logic clk = 1'b0, rst = 1'b1;
  logic hit_we = 1'b0, start = 1'b0;
  logic [5:0] hit_row = '0, hit_col = '0;
  logic [TS_W-1:0] hit_ts = '0;
  logic [AMP_W-1:0] hit_amp = '0;
  logic busy, frame_done, ser_data, ser_valid, rec_start;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // Behavioural pixel model and per-cycle expectation queue {busy,done,valid,start,data}.
  bit             m_hit [NPIX];
  logic [TS_W-1:0]  m_ts [NPIX];
  logic [AMP_W-1:0] m_amp[NPIX];
  logic [4:0] exp_q[$];

  hitchain_readout dut_i (
    .clk(clk), .rst(rst), .hit_we(hit_we), .hit_row(hit_row), .hit_col(hit_col),
    .hit_ts(hit_ts), .hit_amp(hit_amp), .start(start), .busy(busy),
    .frame_done(frame_done), .ser_data(ser_data), .ser_valid(ser_valid),
    .rec_start(rec_start));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_hit(input int r, input int c, input int ts, input int amp);
    @(negedge clk);
    hit_we = 1'b1; hit_row = 6'(r); hit_col = 6'(c);
    hit_ts = TS_W'(ts); hit_amp = AMP_W'(amp);
    @(negedge clk);
    hit_we = 1'b0;
    m_hit[r*COLS+c] = 1'b1;          // R1: capture and overwrite
    m_ts[r*COLS+c]  = TS_W'(ts);
    m_amp[r*COLS+c] = AMP_W'(amp);
  endtask

  // Chain order is ascending row, then column (R3); 2 gap cycles per record (R4).
  task automatic build_frame();
    exp_q.delete();
    for (int idx = 0; idx < NPIX; idx++) begin
      if (m_hit[idx]) begin
        logic [REC_W-1:0] word;
        word = {6'(idx / COLS), 6'(idx % COLS), m_ts[idx], m_amp[idx]};
        exp_q.push_back(5'b10000);
        exp_q.push_back(5'b10000);
        for (int k = REC_W - 1; k >= 0; k--)
          exp_q.push_back({1'b1, 1'b0, 1'b1, (k == REC_W - 1), word[k]});
        m_hit[idx] = 1'b0;               // R6: sent once
      end
    end
    exp_q.push_back(5'b10000);           // trailing scan
    exp_q.push_back(5'b01000);           // R7: done pulse, idle
  endtask

  task automatic run_frame(input int inject_at);
    build_frame();
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < exp_q.size(); i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      check(busy == exp_q[i][4], "R7 busy", busy, exp_q[i][4]);
      check(frame_done == exp_q[i][3], "R7 frame_done", frame_done, exp_q[i][3]);
      check(ser_valid == exp_q[i][2], "R4 ser_valid", ser_valid, exp_q[i][2]);
      check(rec_start == exp_q[i][1], "R5 rec_start", rec_start, exp_q[i][1]);
      if (exp_q[i][2])
        check(ser_data == exp_q[i][0], "R5 ser_data", ser_data, exp_q[i][0]);
      if (i == inject_at) begin
        // R2, R8: write and restart while busy must be ignored.
        start = 1'b1; hit_we = 1'b1; hit_row = 6'd63; hit_col = 6'd62;
        hit_ts = 5'd9; hit_amp = 8'h5A;
      end else if (i == inject_at + 1) begin
        start = 1'b0; hit_we = 1'b0;
      end
    end
    @(negedge clk);
    check(frame_done == 1'b0, "R7 one-cycle pulse", frame_done, 0);
    check(busy == 1'b0, "R8 stays idle after done", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < NPIX; i++) m_hit[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R9 busy after reset", busy, 0);
    check(ser_valid == 1'b0, "R9 ser_valid after reset", ser_valid, 0);
    check(rec_start == 1'b0, "R9 rec_start after reset", rec_start, 0);
    check(frame_done == 1'b0, "R9 frame_done after reset", frame_done, 0);
    run_frame(-5);                              // R9: empty matrix, R7 fast done
    write_hit(0, 0, 31, 8'hFF);                  // R1 single corner pixel
    run_frame(-5);
    write_hit(63, 63, 1, 8'h81);                 // R3 order across distant pixels
    write_hit(0, 63, 17, 8'h3C);
    write_hit(1, 0, 2, 8'h00);
    write_hit(10, 20, 4, 8'h11);
    write_hit(10, 20, 21, 8'hA5);                // R1 overwrite
    write_hit(30, 7, 10, 8'h7E);
    run_frame(-5);
    write_hit(5, 5, 3, 8'h12);                   // R4 adjacent pixels
    write_hit(5, 6, 6, 8'h34);
    write_hit(5, 7, 12, 8'h56);
    run_frame(10);                               // R2, R8 injection mid-frame
    run_frame(-5);                               // R6, R2: nothing left, nothing leaked
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule